// File: doc/BRIEF.md
# DRAM Request Admission and Read Selection Front End

This block sits at the requester side of a DRAM controller. It takes read and write requests from a single valid/ready port. Each legal request is split into a rank, a bank and a row. Writes go into a write queue and reads go into a read queue. The block refuses a request when the matching capacity is used up, and it remembers the refusal so that it can send a retry later. It answers a read directly when a pending write covers the same burst.

Every cycle it offers one read to the DRAM sequencer. The choice follows either strict age order or a row-hit-first order. For the row-hit-first order, the sequencer supplies a per-bank table of open rows. When the sequencer takes a read, that read moves to a "held" count, where it waits for its response time. When the response leaves, the held count drops and a read slot is freed. The write queue is drained oldest first through a head port. DRAM timing, refresh and data storage belong to the neighbouring blocks.

Top module: `mc_admit_arb`

## Requirements
- R1: A read is refused (`req_ready` low) while the queued reads plus the held reads equal `RD_DEPTH`. A read taken with `rd_take` stays counted against this capacity until `rsp_done`.
- R2: A write is refused while the write queue holds `WR_DEPTH` entries. Popping one entry with `wr_take` allows the next write to be accepted.
- R3: A refused request sets a pending retry flag, and an accepted request clears it. `retry` pulses for one cycle, one cycle after a `rsp_done` that releases a held read while the flag is set. It never pulses otherwise.
- R4: An accepted legal read is matched against the write queue using its burst-aligned address (`req_addr` >> log2(`BURST_BYTES`)). On a match, it is answered one cycle later with `ack_kind` = 2 and is not placed in the read queue.
- R5: An accepted legal write is acknowledged one cycle later with `ack_valid` high, `ack_kind` = 1 and its `req_id`.
- R6: With `mode_frfcfs` = 1, the offered read is the oldest queued read whose row equals the open row of its bank (`open_row_valid` set). If no such read exists, the oldest read is offered.
- R7: With `mode_frfcfs` = 0, the offered read is always the oldest queued read.
- R8: A request whose `req_size` is 0 or larger than `BURST_BYTES` is accepted and answered one cycle later with `ack_kind` = 3. It enters neither queue.
- R9: The line address is `req_addr` >> log2(`BURST_BYTES`). The line address is split into fields, from the least significant bit up: column (`COL_W` bits), bank (`BANK_W` bits), rank (`RANK_W` bits) and row (the remaining bits). The open-row table index is {rank, bank}.
- R10: `rd_sel_valid` is low when the read queue is empty. The following are ignored and leave the capacities unchanged: `rd_take` with no read offered, `rsp_done` with no held read, and `wr_take` with an empty write queue.
- R11: `wr_head_addr` shows the line address of the oldest pending write, and `wr_take` advances to the next oldest write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_frfcfs | input | 1 | 1 selects row-hit-first order, 0 selects age order |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when `req_valid` is high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Request size in bytes |
| req_id | input | ID_W | Requester tag |
| ack_valid | output | 1 | Immediate answer present |
| ack_kind | output | 2 | 1 write acknowledged, 2 read forwarded, 3 illegal size |
| ack_id | output | ID_W | Tag of the answered request |
| retry | output | 1 | One-cycle retry pulse to the requester |
| open_row_valid | input | NB | Per-bank open-row flag, indexed by {rank, bank} |
| open_row | input | NB*ROW_W | Per-bank open row, bank b at bits [b*ROW_W +: ROW_W] |
| rd_sel_valid | output | 1 | A read is offered |
| rd_sel_id | output | ID_W | Tag of the offered read |
| rd_sel_rank | output | RANK_W | Rank of the offered read |
| rd_sel_bank | output | BANK_W | Bank of the offered read |
| rd_sel_row | output | ROW_W | Row of the offered read |
| rd_take | input | 1 | Sequencer takes the offered read |
| rsp_done | input | 1 | One held read's response has left |
| wr_head_valid | output | 1 | Write queue is not empty |
| wr_head_addr | output | ADDR_W-log2(BURST_BYTES) | Line address of the oldest write |
| wr_take | input | 1 | Sequencer takes the oldest write |

## Verification
Two functions can land in the same cycle: the sequencer removing the offered read, and a new read being appended. The bench provokes this by raising `rd_take` in the same cycle as a read request. It then checks that only the new read remains on the selection outputs, and that the held count seen through the capacity limit grew by one. The bench also checks refusal and release together. It fills the read capacity with a mix of queued and held reads and confirms that one more read is refused. It then confirms that a single `rsp_done` both produces the retry pulse one cycle later and frees exactly one slot for the next read.

// File: rtl/mc_admit_pkg.sv
// Shared definitions for the DRAM request admission front end.
// Assumes: answer codes are consumed by the requester as two-bit values.
package mc_admit_pkg;

    // Kinds of immediate answer returned on the ack channel
    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_WR   = 2'd1,
        ACK_FWD  = 2'd2,
        ACK_BAD  = 2'd3
    } ack_kind_e;

endpackage

// File: rtl/mc_addr_split.sv
// Splits the upper part of a line address into bank, rank and row fields.
// Assumes: the caller has already removed the burst offset and the column
// bits; field order from LSB is bank, rank, row.
module mc_addr_split #(
    parameter int BANK_W = 3,
    parameter int RANK_W = 1,
    parameter int ROW_W  = 17,
    localparam int HI_W  = BANK_W + RANK_W + ROW_W
) (
    input  logic [HI_W-1:0]   line_hi,
    output logic [BANK_W-1:0] bank,
    output logic [RANK_W-1:0] rank,
    output logic [ROW_W-1:0]  row
);

    // Plain field slicing, no arithmetic on the path
    always_comb begin
        bank = line_hi[0 +: BANK_W];
        rank = line_hi[BANK_W +: RANK_W];
        row  = line_hi[BANK_W+RANK_W +: ROW_W];
    end

endmodule

// File: rtl/mc_wr_queue.sv
// Circular write queue holding burst line addresses. It offers the oldest
// entry at its head and compares a probe line against every live entry
// in the same cycle, for read forwarding.
// Assumes: the caller never pushes into a full queue; a pop on an empty
// queue is ignored here.
module mc_wr_queue #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 26,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit,
    output logic              head_valid,
    output logic [LINE_W-1:0] head_line,
    output logic [CNT_W-1:0]  count
);

    logic [LINE_W-1:0] slot_line [DEPTH];
    logic [DEPTH-1:0]  slot_live;
    logic [IDX_W-1:0]  wr_ptr, rd_ptr;
    logic              pop_ok;

    assign pop_ok     = pop && (count != '0);
    assign head_valid = (count != '0);
    assign head_line  = slot_line[rd_ptr];

    // Forwarding probe: any live slot holding the same line
    always_comb begin
        probe_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_live[i] && (slot_line[i] == probe_line))
                probe_hit = 1'b1;
        end
    end

    // Pointer, occupancy and slot-liveness update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            slot_live <= '0;
        end else begin
            if (push) begin
                slot_live[wr_ptr] <= 1'b1;
                wr_ptr <= (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                slot_live[rd_ptr] <= 1'b0;
                rd_ptr <= (rd_ptr == IDX_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop_ok)
                count <= count + 1'b1;
            else if (!push && pop_ok)
                count <= count - 1'b1;
        end
    end

    // Line storage; written only on push
    always_ff @(posedge clk) begin
        if (push)
            slot_line[wr_ptr] <= push_line;
    end

    // R2: the write queue never grows past its depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop_ok) |-> (count < CNT_W'(DEPTH)));

    // R11: a pop changes the head slot unless the queue becomes empty
    p_head_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push && count > CNT_W'(1)) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/mc_rd_queue.sv
// Age-ordered read queue with a per-cycle selector. Index 0 is the oldest
// entry; removal compacts the younger entries down by one. The selector
// offers the oldest entry, or under row-hit-first order the oldest entry
// whose row is open in its bank.
// Assumes: pop is only raised while sel_valid is high; push is only raised
// when the caller's capacity check allows it.
module mc_rd_queue #(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 4,
    parameter int BANK_W = 3,
    parameter int RANK_W = 1,
    parameter int ROW_W  = 17,
    localparam int RB_W  = RANK_W + BANK_W,
    localparam int NB    = 1 << RB_W,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frfcfs,
    input  logic                push,
    input  logic [ID_W-1:0]     push_id,
    input  logic [RANK_W-1:0]   push_rank,
    input  logic [BANK_W-1:0]   push_bank,
    input  logic [ROW_W-1:0]    push_row,
    input  logic                pop,
    input  logic [NB-1:0]       open_vld,
    input  logic [NB*ROW_W-1:0] open_rows,
    output logic [CNT_W-1:0]    count,
    output logic                sel_valid,
    output logic [ID_W-1:0]     sel_id,
    output logic [RANK_W-1:0]   sel_rank,
    output logic [BANK_W-1:0]   sel_bank,
    output logic [ROW_W-1:0]    sel_row
);

    logic [ID_W-1:0]   q_id   [DEPTH];
    logic [RANK_W-1:0] q_rank [DEPTH];
    logic [BANK_W-1:0] q_bank [DEPTH];
    logic [ROW_W-1:0]  q_row  [DEPTH];

    logic [ID_W-1:0]   n_id   [DEPTH];
    logic [RANK_W-1:0] n_rank [DEPTH];
    logic [BANK_W-1:0] n_bank [DEPTH];
    logic [ROW_W-1:0]  n_row  [DEPTH];
    logic [CNT_W-1:0]  n_count;

    logic [DEPTH-1:0]  row_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic              hit_found;

    // Per-entry comparison against the open row of the entry's bank
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            row_hit[i] = (CNT_W'(i) < count)
                      && open_vld[{q_rank[i], q_bank[i]}]
                      && (open_rows[{q_rank[i], q_bank[i]}*ROW_W +: ROW_W] == q_row[i]);
        end
    end

    // Selection: oldest by default, first row hit in age order when enabled
    always_comb begin
        sel_idx   = '0;
        hit_found = 1'b0;
        if (frfcfs && count > CNT_W'(1)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!hit_found && row_hit[i]) begin
                    sel_idx   = IDX_W'(i);
                    hit_found = 1'b1;
                end
            end
        end
    end

    assign sel_valid = (count != '0);
    assign sel_id    = q_id[sel_idx];
    assign sel_rank  = q_rank[sel_idx];
    assign sel_bank  = q_bank[sel_idx];
    assign sel_row   = q_row[sel_idx];

    // Next-state: compact out the selected entry, then append the new one
    always_comb begin
        n_id    = q_id;
        n_rank  = q_rank;
        n_bank  = q_bank;
        n_row   = q_row;
        n_count = count;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= sel_idx) begin
                    n_id[i]   = q_id[i+1];
                    n_rank[i] = q_rank[i+1];
                    n_bank[i] = q_bank[i+1];
                    n_row[i]  = q_row[i+1];
                end
            end
            n_count = count - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == n_count) begin
                    n_id[i]   = push_id;
                    n_rank[i] = push_rank;
                    n_bank[i] = push_bank;
                    n_row[i]  = push_row;
                end
            end
            n_count = n_count + 1'b1;
        end
    end

    // Occupancy register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= n_count;
    end

    // Entry storage; contents beyond count are don't-care
    always_ff @(posedge clk) begin
        q_id   <= n_id;
        q_rank <= n_rank;
        q_bank <= n_bank;
        q_row  <= n_row;
    end

    // R1: the caller never appends into a full queue
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CNT_W'(DEPTH)));

    // R6: a non-oldest pick under row-hit-first order must be an open-row hit
    p_pick_is_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frfcfs && sel_valid && sel_idx != '0) |->
        (open_vld[{sel_rank, sel_bank}] &&
         open_rows[{sel_rank, sel_bank}*ROW_W +: ROW_W] == sel_row));

    // R7: age order always offers entry 0
    p_age_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frfcfs && sel_valid) |-> (sel_idx == '0));

    // R10: a pop without an offered read is a caller bug
    p_pop_needs_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> sel_valid);

endmodule

// File: rtl/mc_admit_arb.sv
// Admission front end of a DRAM controller: legality and capacity checks,
// write acknowledgement, read forwarding from pending writes, retry
// bookkeeping for refused requests, and the per-cycle read selection.
// Assumes: one request per cycle; the sequencer raises rsp_done once per
// read whose response has left; DRAM timing lives downstream.
module mc_admit_arb
    import mc_admit_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 64,
    parameter int SIZE_W      = 8,
    parameter int ID_W        = 4,
    parameter int COL_W       = 5,
    parameter int BANK_W      = 3,
    parameter int RANK_W      = 1,
    parameter int RD_DEPTH    = 8,
    parameter int WR_DEPTH    = 8,
    parameter int ROW_W       = ADDR_W - $clog2(BURST_BYTES) - COL_W - BANK_W - RANK_W,
    parameter int NB          = 1 << (RANK_W + BANK_W),
    parameter int LINE_W      = ADDR_W - $clog2(BURST_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_frfcfs,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic [ID_W-1:0]      req_id,
    output logic                 ack_valid,
    output logic [1:0]           ack_kind,
    output logic [ID_W-1:0]      ack_id,
    output logic                 retry,
    input  logic [NB-1:0]        open_row_valid,
    input  logic [NB*ROW_W-1:0]  open_row,
    output logic                 rd_sel_valid,
    output logic [ID_W-1:0]      rd_sel_id,
    output logic [RANK_W-1:0]    rd_sel_rank,
    output logic [BANK_W-1:0]    rd_sel_bank,
    output logic [ROW_W-1:0]     rd_sel_row,
    input  logic                 rd_take,
    input  logic                 rsp_done,
    output logic                 wr_head_valid,
    output logic [LINE_W-1:0]    wr_head_addr,
    input  logic                 wr_take
);

    localparam int OFF_W    = $clog2(BURST_BYTES);
    localparam int HI_W     = LINE_W - COL_W;
    localparam int RCNT_W   = $clog2(RD_DEPTH + 1);
    localparam int WCNT_W   = $clog2(WR_DEPTH + 1);
    localparam int TOT_W    = RCNT_W + 1;

    if (BURST_BYTES != 32 && BURST_BYTES != 64) begin : g_bad_burst
        $error("burst size must be 32 or 64 bytes");
    end

    logic [LINE_W-1:0]  req_line;
    logic [OFF_W-1:0]   addr_offset_unused;
    logic [BANK_W-1:0]  dec_bank;
    logic [RANK_W-1:0]  dec_rank;
    logic [ROW_W-1:0]   dec_row;
    logic               req_legal;
    logic               rd_full, wr_full;
    logic               accept, refuse;
    logic               fwd_hit;
    logic               rd_push, wr_push;
    logic               take_ok, done_ok;
    logic [RCNT_W-1:0]  rq_count;
    logic [WCNT_W-1:0]  wq_count;
    logic [RCNT_W-1:0]  held_count;
    logic [TOT_W-1:0]   rd_total;
    logic               retry_pend;

    assign req_line           = req_addr[ADDR_W-1:OFF_W];
    assign addr_offset_unused = req_addr[OFF_W-1:0];

    mc_addr_split #(
        .BANK_W (BANK_W),
        .RANK_W (RANK_W),
        .ROW_W  (ROW_W)
    ) u_split (
        .line_hi (req_line[LINE_W-1:COL_W]),
        .bank    (dec_bank),
        .rank    (dec_rank),
        .row     (dec_row)
    );

    // Size legality: non-zero and no larger than one burst
    assign req_legal = (req_size != '0) && (req_size <= SIZE_W'(BURST_BYTES));

    // Capacity: reads count queued plus held entries
    assign rd_total = TOT_W'(rq_count) + TOT_W'(held_count);
    assign rd_full  = (rd_total == TOT_W'(RD_DEPTH));
    assign wr_full  = (wq_count == WCNT_W'(WR_DEPTH));

    // Ready: illegal requests are always taken and answered
    always_comb begin
        if (!req_legal)
            req_ready = 1'b1;
        else if (req_write)
            req_ready = !wr_full;
        else
            req_ready = !rd_full;
    end

    assign accept  = req_valid && req_ready;
    assign refuse  = req_valid && !req_ready;
    assign rd_push = accept && req_legal && !req_write && !fwd_hit;
    assign wr_push = accept && req_legal && req_write;
    assign take_ok = rd_take && rd_sel_valid;
    assign done_ok = rsp_done && (held_count != '0);

    mc_wr_queue #(
        .DEPTH  (WR_DEPTH),
        .LINE_W (LINE_W)
    ) u_wrq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_push),
        .push_line  (req_line),
        .pop        (wr_take),
        .probe_line (req_line),
        .probe_hit  (fwd_hit),
        .head_valid (wr_head_valid),
        .head_line  (wr_head_addr),
        .count      (wq_count)
    );

    mc_rd_queue #(
        .DEPTH  (RD_DEPTH),
        .ID_W   (ID_W),
        .BANK_W (BANK_W),
        .RANK_W (RANK_W),
        .ROW_W  (ROW_W)
    ) u_rdq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frfcfs    (mode_frfcfs),
        .push      (rd_push),
        .push_id   (req_id),
        .push_rank (dec_rank),
        .push_bank (dec_bank),
        .push_row  (dec_row),
        .pop       (take_ok),
        .open_vld  (open_row_valid),
        .open_rows (open_row),
        .count     (rq_count),
        .sel_valid (rd_sel_valid),
        .sel_id    (rd_sel_id),
        .sel_rank  (rd_sel_rank),
        .sel_bank  (rd_sel_bank),
        .sel_row   (rd_sel_row)
    );

    // Held reads: taken by the sequencer, waiting for their response
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_count <= '0;
        else if (take_ok && !done_ok)
            held_count <= held_count + 1'b1;
        else if (!take_ok && done_ok)
            held_count <= held_count - 1'b1;
    end

    // Immediate answers: write ack, forwarded read, illegal size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_kind  <= ACK_NONE;
            ack_id    <= '0;
        end else begin
            ack_valid <= accept && (!req_legal || req_write || fwd_hit);
            ack_id    <= req_id;
            if (!req_legal)
                ack_kind <= ACK_BAD;
            else if (req_write)
                ack_kind <= ACK_WR;
            else if (fwd_hit)
                ack_kind <= ACK_FWD;
            else
                ack_kind <= ACK_NONE;
        end
    end

    // Retry flag: set on refusal, cleared on acceptance or when the retry goes out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_pend <= 1'b0;
            retry      <= 1'b0;
        end else begin
            retry <= retry_pend && done_ok;
            if (refuse)
                retry_pend <= 1'b1;
            else if (accept || done_ok)
                retry_pend <= 1'b0;
        end
    end

    // R1: read occupancy including held reads stays within the buffer
    p_rd_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_total <= TOT_W'(RD_DEPTH));

    // R3: a retry pulse always follows a response leaving
    p_retry_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> $past(rsp_done));

    // R4: a forwarded read is answered next cycle and not queued
    p_fwd_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_legal && !req_write && fwd_hit) |=>
        (ack_valid && ack_kind == ACK_FWD && rq_count <= $past(rq_count)));

    // R5: an accepted write is acknowledged next cycle
    p_wr_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_legal && req_write) |=> (ack_valid && ack_kind == ACK_WR));

    // R8: an illegal request is answered next cycle and enters no queue
    p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_legal) |=>
        (ack_kind == ACK_BAD && rq_count <= $past(rq_count) && wq_count <= $past(wq_count)));

endmodule

// File: tb/mc_admit_arb_tb.sv
module mc_admit_arb_tb;

    localparam int ROW_W  = 17;
    localparam int NB     = 16;
    localparam int LINE_W = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_frfcfs = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [7:0]        req_size = '0;
    logic [3:0]        req_id = '0;
    logic              ack_valid;
    logic [1:0]        ack_kind;
    logic [3:0]        ack_id;
    logic              retry;
    logic [NB-1:0]     open_row_valid = '0;
    logic [NB*ROW_W-1:0] open_row = '0;
    logic              rd_sel_valid;
    logic [3:0]        rd_sel_id;
    logic [0:0]        rd_sel_rank;
    logic [2:0]        rd_sel_bank;
    logic [ROW_W-1:0]  rd_sel_row;
    logic              rd_take = 1'b0;
    logic              rsp_done = 1'b0;
    logic              wr_head_valid;
    logic [LINE_W-1:0] wr_head_addr;
    logic              wr_take = 1'b0;

    int total = 0;
    int bad = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    mc_admit_arb u_dut (
        .clk(clk), .rst_n(rst_n), .mode_frfcfs(mode_frfcfs),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_id(req_id),
        .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_id(ack_id),
        .retry(retry), .open_row_valid(open_row_valid), .open_row(open_row),
        .rd_sel_valid(rd_sel_valid), .rd_sel_id(rd_sel_id),
        .rd_sel_rank(rd_sel_rank), .rd_sel_bank(rd_sel_bank),
        .rd_sel_row(rd_sel_row), .rd_take(rd_take), .rsp_done(rsp_done),
        .wr_head_valid(wr_head_valid), .wr_head_addr(wr_head_addr),
        .wr_take(wr_take)
    );

    function automatic logic [31:0] mk(input int row, input int rank, input int bank, input int col);
        return {row[16:0], rank[0], bank[2:0], col[4:0], 6'b0};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: present one request for one cycle, record the expected answer
    task automatic send(input bit wr, input logic [31:0] a, input int sz,
                        input int id, input int kind, output bit acc);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz[7:0];
        req_id    = id[3:0];
        #1;
        acc = req_ready;
        if (acc && kind != 0)
            exp_q.push_back(kind * 256 + (id % 16));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_take();
        rd_take = 1'b1;
        @(negedge clk);
        rd_take = 1'b0;
    endtask

    task automatic pulse_wtake();
        wr_take = 1'b1;
        @(negedge clk);
        wr_take = 1'b0;
    endtask

    // Monitor: pop the scoreboard whenever an answer appears
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R5/R4/R8 unexpected answer actual=%0d expected=none", ack_kind);
            end else begin
                int e;
                string rq;
                e = exp_q.pop_front();
                rq = (e / 256 == 1) ? "R5" : (e / 256 == 2) ? "R4" : "R8";
                check({rq, " ack kind"}, ack_kind, e / 256);
                check({rq, " ack id"}, ack_id, e % 256);
            end
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit acc;
        logic [31:0] w_addr;
        logic [31:0] first_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R10)
        check("R10 reset sel valid", rd_sel_valid, 0);
        check("R10 reset wr head", wr_head_valid, 0);
        check("R3 reset retry", retry, 0);
        check("R1 reset ready", req_ready, 1);

        // Age order and field split (R7, R9)
        send(0, mk(5, 0, 2, 1), 64, 1, 0, acc);
        send(0, mk(7, 1, 3, 0), 32, 2, 0, acc);
        open_row[11*ROW_W +: ROW_W] = 17'd7;
        open_row_valid[11] = 1'b1;
        #1;
        check("R7 oldest offered", rd_sel_id, 1);
        check("R9 rank", rd_sel_rank, 0);
        check("R9 bank", rd_sel_bank, 2);
        check("R9 row", rd_sel_row, 5);

        // Row-hit-first order (R6)
        mode_frfcfs = 1'b1;
        #1;
        check("R6 row hit picked", rd_sel_id, 2);
        check("R9 rank of hit", rd_sel_rank, 1);
        open_row[2*ROW_W +: ROW_W] = 17'd5;
        open_row_valid[2] = 1'b1;
        #1;
        check("R6 oldest hit first", rd_sel_id, 1);
        open_row_valid = '0;
        #1;
        check("R6 no hit oldest", rd_sel_id, 1);
        open_row_valid[11] = 1'b1;
        #1;
        @(negedge clk);
        pulse_take();
        check("R6 remaining after take", rd_sel_id, 1);

        // Take and arrival in the same cycle (held now 2)
        rd_take = 1'b1;
        send(0, mk(9, 0, 4, 2), 16, 3, 0, acc);
        rd_take = 1'b0;
        check("R7 only newest left", rd_sel_id, 3);

        // Illegal sizes (R8)
        send(0, mk(1, 0, 0, 0), 0, 4, 3, acc);
        check("R8 zero size accepted", acc, 1);
        send(1, mk(1, 0, 0, 0), 65, 5, 3, acc);
        check("R8 oversize accepted", acc, 1);
        check("R8 not queued", rd_sel_id, 3);
        check("R8 no write queued", wr_head_valid, 0);

        // Write acknowledged and queued (R5, R11)
        w_addr = mk(20, 0, 6, 7);
        send(1, w_addr, 64, 6, 1, acc);
        check("R11 head valid", wr_head_valid, 1);
        check("R11 head line", int'(wr_head_addr), int'(w_addr >> 6));

        // Forwarded read to an unaligned address in the same burst (R4)
        send(0, w_addr + 32'd8, 8, 7, 2, acc);
        pulse_take();
        check("R4 forwarded read not queued", rd_sel_valid, 0);

        // Ignored take on empty queue (R10), then fill capacity (R1); held=3
        pulse_take();
        for (int i = 0; i < 5; i++) begin
            send(0, mk(40 + i, 0, 1, 0), 64, 8 + i, 0, acc);
            check("R1 read accepted below capacity", acc, 1);
        end
        send(0, mk(50, 0, 1, 0), 64, 13, 0, acc);
        check("R1 read refused at capacity", acc, 0);
        check("R3 no retry before release", retry, 0);

        // Release one held read: retry pulse and a freed slot (R3, R1)
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        check("R3 retry pulse", retry, 1);
        @(negedge clk);
        check("R3 retry single cycle", retry, 0);
        send(0, mk(50, 0, 1, 0), 64, 13, 0, acc);
        check("R1 read accepted after release", acc, 1);

        // Write capacity (R2) and head order (R11)
        for (int i = 0; i < 7; i++) begin
            send(1, mk(30 + i, 1, 0, 1), 64, i, 1, acc);
            check("R2 write accepted below capacity", acc, 1);
        end
        first_w = mk(30, 1, 0, 1);
        send(1, mk(60, 0, 0, 0), 64, 14, 1, acc);
        check("R2 write refused at capacity", acc, 0);
        check("R11 head still oldest", int'(wr_head_addr), int'(w_addr >> 6));
        pulse_wtake();
        check("R11 head advanced", int'(wr_head_addr), int'(first_w >> 6));
        send(1, mk(60, 0, 0, 0), 64, 14, 1, acc);
        check("R2 write accepted after pop", acc, 1);

        // Drain, extra pop ignored (R10), then a fresh write is the head
        for (int i = 0; i < 8; i++) pulse_wtake();
        check("R11 drained", wr_head_valid, 0);
        pulse_wtake();
        send(1, mk(70, 0, 3, 3), 64, 15, 1, acc);
        check("R10 head after ignored pop", int'(wr_head_addr), int'(mk(70, 0, 3, 3) >> 6));
        check("R10 single entry", wr_head_valid, 1);

        repeat (3) @(negedge clk);
        check("R5 all answers seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule